// File: doc/BRIEF.md
# Flexible-Rate Concatenated Parity Encoder

This block turns a frame of K information bits into a systematic codeword for a low-complexity concatenated code. The bits arrive serially on a ready/valid input, one per beat, with a flag on the opening beat and a flag on the closing beat. The opening beat also samples three settings: the frame length in bytes, a rate selector and an interleaver step. Once the frame is stored, the encoder sends the K information bits unchanged and then the parity bits, one per beat, on a ready/valid output.

The parity path has four stages. The first is a two-state rate-1/2 outer code with both taps equal to 1+D, run tail-biting over the frame. Next, a relative-prime interleaver reads its 2K coded bits in a fixed stride. A single-parity-check combiner then folds each group of J interleaved bits into one bit. Last, a two-state accumulator turns the check values into the transmitted parity. Only J changes between code rates, and the rate is J/(J+2).

Top module: `flex_ldpc_enc`

## Requirements
- R1: During reset and on the cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: After a frame is stored, the K information bits leave first, in arrival order, with `out_is_parity` = 0.
- R3: Next come V = ceil(2K/J) parity beats with `out_is_parity` = 1, where J = 2 << `cfg_rate_sel` (selector 0..4 gives J = 2, 4, 8, 16, 32).
- R4: Parity beat v carries p_v = p_(v-1) XOR e_v, with p_(-1) = 0 for every frame. e_v is the XOR of interleaved bits vJ .. vJ+J-1, and positions at or beyond 2K count as 0.
- R5: The outer coded bit for information index k is c_k = b_k XOR b_((k-1) mod K), so c_0 uses b_(K-1). Interleaver address a reads c_(a>>1), so each c_k occurs twice.
- R6: Interleaved position i reads address (i * S) mod 2K, where S is `cfg_step` as sampled at frame start. S must be coprime to 2K and below it.
- R7: `out_last` is 1 on the final parity beat of a frame and 0 on every other beat.
- R8: `in_ready` stays 0 from the moment a frame is complete until its last output beat is accepted. After that, a new frame is accepted.
- R9: While idle, input beats with `in_first` = 0 are accepted and discarded, and they produce no output.
- R10: A beat with `in_last` = 1 before the K-th bit abandons the frame. No output follows, and the block returns to idle.
- R11: K = 8 * `cfg_bytes`, for `cfg_bytes` from 3 to MAX_BYTES (default 1000), sampled on the beat that carries `in_first`.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_last` and `out_is_parity` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bytes | input | 10 | Frame length in bytes, sampled with `in_first` |
| cfg_rate_sel | input | 3 | Rate selector, J = 2 << value |
| cfg_step | input | 14 | Interleaver stride S |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Encoder accepts an input bit |
| in_data | input | 1 | Information bit |
| in_first | input | 1 | Opening beat of a frame |
| in_last | input | 1 | Closing beat of a frame |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_data | output | 1 | Codeword bit |
| out_is_parity | output | 1 | 1 while the parity section is being sent |
| out_last | output | 1 | Final beat of the codeword |

## Verification
The hardest situation to reach from the ports is a partial final check group. Here 2K is not a multiple of J, so the last group has to be padded with zeros and the frame has to end on that padded group. The stimulus reaches it with a 5-byte frame at J = 32, where 80 interleaved bits form three groups. The wrap of the tail-biting outer code is checked with a unit stride, because the first coded bit then lands directly in parity group zero. A stride of 2K-1 runs the interleaver backwards through the frame. Random output backpressure holds parity beats while the fold logic is paused.

// File: rtl/flex_ldpc_pkg.sv
package flex_ldpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SYS,
        ST_FOLD,
        ST_EMIT
    } enc_state_e;

    localparam int unsigned MAX_RATE_SEL = 4;
    localparam int unsigned GRP_W        = 6;

    // Check-group length for a rate selector; selectors above the top one saturate.
    function automatic logic [GRP_W-1:0] group_len(input logic [2:0] sel);
        logic [2:0] s;
        s = (sel > 3'(MAX_RATE_SEL)) ? 3'(MAX_RATE_SEL) : sel;
        return GRP_W'(6'd2 << s);
    endfunction

endpackage

// File: rtl/flex_ldpc_frame_buf.sv
module flex_ldpc_frame_buf #(
    parameter int MAX_BITS = 8000,
    parameter int WORD_W   = 32,
    localparam int IW      = $clog2(MAX_BITS),
    localparam int DEPTH   = (MAX_BITS + WORD_W - 1) / WORD_W,
    localparam int AW      = $clog2(DEPTH),
    localparam int OW      = $clog2(WORD_W)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_bit,
    input  logic [IW-1:0] rd0_idx,
    input  logic [IW-1:0] rd1_idx,
    output logic          rd0_bit,
    output logic          rd1_bit
);

    logic [WORD_W-1:0] mem [DEPTH];

    logic [AW-1:0] wr_word, rd0_word, rd1_word;

    assign wr_word  = AW'(wr_idx  >> OW);
    assign rd0_word = AW'(rd0_idx >> OW);
    assign rd1_word = AW'(rd1_idx >> OW);

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_word][wr_idx[OW-1:0]] <= wr_bit;
        end
    end

    assign rd0_bit = mem[rd0_word][rd0_idx[OW-1:0]];
    assign rd1_bit = mem[rd1_word][rd1_idx[OW-1:0]];

endmodule

// File: rtl/flex_ldpc_ilv_addr.sv
module flex_ldpc_ilv_addr #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] addr
);

    logic [AW:0] sum, wrapped;

    // Stride addition with a single conditional subtract: no multiplier, no table.
    always_comb begin
        sum     = {1'b0, addr} + {1'b0, step};
        wrapped = (sum >= {1'b0, span}) ? (sum - {1'b0, span}) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            addr <= '0;
        end else if (adv) begin
            addr <= wrapped[AW-1:0];
        end
    end

endmodule

// File: rtl/flex_ldpc_par_fold.sv
module flex_ldpc_par_fold #(
    parameter int TW = 14,
    parameter int JW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          adv,
    input  logic          e_bit,
    input  logic [JW-1:0] j_len,
    input  logic [TW-1:0] span,
    output logic          grp_done,
    output logic          parity,
    output logic          fin
);

    logic [TW-1:0] t_cnt;
    logic [JW-1:0] j_cnt;
    logic          grp_acc;
    logic          accum;
    logic          eff;
    logic          nxt_par;

    // Positions past the end of the interleaved frame pad the last group with zeros.
    assign eff      = (t_cnt < span) ? e_bit : 1'b0;
    assign grp_done = adv && (j_cnt == j_len - JW'(1));
    assign nxt_par  = accum ^ grp_acc ^ eff;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            t_cnt   <= '0;
            j_cnt   <= '0;
            grp_acc <= 1'b0;
            accum   <= 1'b0;
            parity  <= 1'b0;
            fin     <= 1'b0;
        end else if (adv) begin
            t_cnt <= t_cnt + TW'(1);
            if (grp_done) begin
                j_cnt   <= '0;
                grp_acc <= 1'b0;
                accum   <= nxt_par;
                parity  <= nxt_par;
                fin     <= ((t_cnt + TW'(1)) >= span);
            end else begin
                j_cnt   <= j_cnt + JW'(1);
                grp_acc <= grp_acc ^ eff;
            end
        end
    end

endmodule

// File: rtl/flex_ldpc_enc.sv
module flex_ldpc_enc
    import flex_ldpc_pkg::*;
#(
    parameter int MAX_BYTES = 1000,
    parameter int WORD_W    = 32,
    localparam int MAX_K    = MAX_BYTES * 8,
    localparam int BW       = $clog2(MAX_BYTES + 1),
    localparam int KW       = $clog2(MAX_K + 1),
    localparam int IW       = $clog2(MAX_K),
    localparam int SW       = $clog2(2 * MAX_K + 1),
    localparam int TW       = $clog2(2 * MAX_K + 64)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] cfg_bytes,
    input  logic [2:0]    cfg_rate_sel,
    input  logic [SW-1:0] cfg_step,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_data,
    input  logic          in_first,
    input  logic          in_last,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_data,
    output logic          out_is_parity,
    output logic          out_last
);

    typedef struct packed {
        logic [KW-1:0]    k_len;
        logic [SW-1:0]    span;
        logic [GRP_W-1:0] j_len;
        logic [SW-1:0]    step;
    } frame_cfg_t;

    enc_state_e state;
    frame_cfg_t cfg, cfg_next;
    logic [IW-1:0] wr_idx, sys_idx;
    logic [IW-1:0] k_last, k_cur, k_prev, rd0_idx;
    logic [SW-1:0] ilv_addr;
    logic          rd0_bit, rd1_bit;
    logic          wr_en, fold_clr, fold_adv, grp_done, par_bit, par_fin;

    always_comb begin
        cfg_next.k_len = KW'({cfg_bytes, 3'b000});
        cfg_next.span  = SW'({cfg_bytes, 4'b0000});
        cfg_next.j_len = group_len(cfg_rate_sel);
        cfg_next.step  = cfg_step;
    end

    assign k_last  = IW'(cfg.k_len - KW'(1));
    // Outer code read on the fly: address pair 2k, 2k+1 both map to c_k.
    assign k_cur   = IW'(ilv_addr >> 1);
    assign k_prev  = (k_cur == '0) ? k_last : (k_cur - IW'(1));
    assign rd0_idx = (state == ST_SYS) ? sys_idx : k_cur;

    assign in_ready = (state == ST_IDLE) || (state == ST_LOAD);
    assign wr_en    = in_valid && ((state == ST_LOAD) || ((state == ST_IDLE) && in_first));
    assign fold_clr = (state == ST_SYS);
    assign fold_adv = (state == ST_FOLD);

    flex_ldpc_frame_buf #(
        .MAX_BITS (MAX_K),
        .WORD_W   (WORD_W)
    ) i_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  ((state == ST_IDLE) ? '0 : wr_idx),
        .wr_bit  (in_data),
        .rd0_idx (rd0_idx),
        .rd1_idx (k_prev),
        .rd0_bit (rd0_bit),
        .rd1_bit (rd1_bit)
    );

    flex_ldpc_ilv_addr #(
        .AW (SW)
    ) i_addr (
        .clk  (clk),
        .rst  (rst),
        .load (fold_clr),
        .adv  (fold_adv),
        .step (cfg.step),
        .span (cfg.span),
        .addr (ilv_addr)
    );

    flex_ldpc_par_fold #(
        .TW (TW),
        .JW (GRP_W)
    ) i_fold (
        .clk      (clk),
        .rst      (rst),
        .clr      (fold_clr),
        .adv      (fold_adv),
        .e_bit    (rd0_bit ^ rd1_bit),
        .j_len    (cfg.j_len),
        .span     (TW'(cfg.span)),
        .grp_done (grp_done),
        .parity   (par_bit),
        .fin      (par_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            wr_idx  <= '0;
            sys_idx <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid && in_first) begin
                        cfg    <= cfg_next;
                        wr_idx <= IW'(1);
                        if (!in_last) state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        if (wr_idx == k_last) begin
                            state   <= ST_SYS;
                            sys_idx <= '0;
                        end else if (in_last) begin
                            state <= ST_IDLE;
                        end else begin
                            wr_idx <= wr_idx + IW'(1);
                        end
                    end
                end
                ST_SYS: begin
                    if (out_ready) begin
                        if (sys_idx == k_last) state <= ST_FOLD;
                        else sys_idx <= sys_idx + IW'(1);
                    end
                end
                ST_FOLD: begin
                    if (grp_done) state <= ST_EMIT;
                end
                ST_EMIT: begin
                    if (out_ready) state <= par_fin ? ST_IDLE : ST_FOLD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign out_valid     = (state == ST_SYS) || (state == ST_EMIT);
    assign out_data      = (state == ST_SYS) ? rd0_bit : par_bit;
    assign out_is_parity = (state == ST_FOLD) || (state == ST_EMIT);
    assign out_last      = (state == ST_EMIT) && par_fin;

endmodule

// File: rtl/flex_ldpc_enc_chk.sv
module flex_ldpc_enc_chk (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic out_data,
    input logic out_is_parity,
    input logic out_last
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && in_ready));

    p_par_order_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_parity && !out_last) |=> out_is_parity);

    p_last_in_par_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> out_is_parity);

    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_is_parity)));

endmodule

bind flex_ldpc_enc flex_ldpc_enc_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_is_parity (out_is_parity),
    .out_last      (out_last)
);

// File: tb/test_flex_ldpc_enc.sv
module test_flex_ldpc_enc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  cfg_bytes = '0;
    logic [2:0]  cfg_rate_sel = '0;
    logic [13:0] cfg_step = '0;
    logic        in_valid = 1'b0, in_data = 1'b0, in_first = 1'b0, in_last = 1'b0;
    logic        out_ready = 1'b0;
    logic        in_ready, out_valid, out_data, out_is_parity, out_last;

    always #4 clk = ~clk;

    flex_ldpc_enc i_flex_ldpc_enc (
        .clk(clk), .rst(rst), .cfg_bytes(cfg_bytes), .cfg_rate_sel(cfg_rate_sel),
        .cfg_step(cfg_step), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_first(in_first), .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_is_parity(out_is_parity), .out_last(out_last)
    );

    int checks = 0, failures = 0;
    logic [2:0] exp_q[$];          // {is_parity, last, data}
    bit   tb_b[0:7999];
    bit   ready_mode = 0;
    bit   run_done = 0;
    int   sys_seen = 0, par_seen = 0;
    string tag = "R2/R4";

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: drives out_ready at the negedge and scores the beat taken at the next posedge.
    initial begin : monitor
        bit hold_pend = 0;
        logic [2:0] held = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                bit rdy;
                if (hold_pend)
                    check(out_valid && ({out_is_parity, out_last, out_data} == held),
                          "R12", int'({out_valid, out_is_parity, out_last, out_data}),
                          int'({1'b1, held}));
                rdy = ready_mode ? bit'($urandom % 2) : 1'b1;
                out_ready = rdy;
                hold_pend = out_valid && !rdy;
                held = {out_is_parity, out_last, out_data};
                if (out_valid) check(!in_ready, "R8", int'(in_ready), 0);
                if (out_valid && rdy) begin
                    if (out_is_parity) par_seen++; else sys_seen++;
                    if (exp_q.size() == 0) begin
                        check(0, "R9/R10 unexpected beat", int'(held), 0);
                    end else begin
                        logic [2:0] e;
                        e = exp_q.pop_front();
                        check(out_data == e[0], tag, int'(out_data), int'(e[0]));
                        check(out_last == e[1], "R7", int'(out_last), int'(e[1]));
                        check(out_is_parity == e[2], "R3", int'(out_is_parity), int'(e[2]));
                    end
                end
            end
        end
    end

    task automatic drive_bits(input int nbits, input int abort_at, input int bytes,
                              input int sel, input int step);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            in_valid = 1; in_data = tb_b[i]; in_first = (i == 0);
            in_last = (i == nbits - 1) || (i == abort_at);
            cfg_bytes = 10'(bytes); cfg_rate_sel = 3'(sel); cfg_step = 14'(step);
            while (!in_ready) @(negedge clk);
            if (i == abort_at) break;
        end
        @(negedge clk);
        in_valid = 0; in_first = 0; in_last = 0;
    endtask

    // Driver: computes the expected codeword from the requirements, queues it, sends the frame.
    task automatic send_frame(input int bytes, input int sel, input int step);
        int k, span, j, v;
        bit acc;
        k = bytes * 8; span = 2 * k; j = 2 << sel; v = (span + j - 1) / j;
        for (int i = 0; i < k; i++) tb_b[i] = bit'($urandom % 2);
        for (int i = 0; i < k; i++) exp_q.push_back({1'b0, 1'b0, tb_b[i]});
        acc = 0;
        for (int g = 0; g < v; g++) begin
            bit grp;
            grp = 0;
            for (int m = 0; m < j; m++) begin
                int t;
                t = g * j + m;
                if (t < span) begin
                    longint a;
                    int kk;
                    a = (longint'(t) * step) % span;
                    kk = int'(a / 2);
                    grp ^= tb_b[kk] ^ tb_b[(kk + k - 1) % k];
                end
            end
            acc ^= grp;
            exp_q.push_back({1'b1, (g == v - 1), acc});
        end
        sys_seen = 0; par_seen = 0;
        drive_bits(k, -1, bytes, sel, step);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(sys_seen == k, "R11", sys_seen, k);
        check(par_seen == v, "R3", par_seen, v);
        check(in_ready == 1, "R8", int'(in_ready), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!run_done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        check(out_valid == 0, "R1", int'(out_valid), 0);
        check(in_ready == 1, "R1", int'(in_ready), 1);
        rst = 0;
        @(negedge clk);
        check(out_valid == 0 && in_ready == 1, "R1", int'({out_valid, in_ready}), 1);

        tag = "R2/R4/R6";
        send_frame(3, 0, 7);            // K=24, J=2, rate 1/2
        tag = "R4 padded group";
        send_frame(5, 4, 3);            // 2K=80, J=32: three groups, last padded
        tag = "R5 tail-biting";
        send_frame(4, 2, 1);            // unit stride: c_0 = b_0 ^ b_(K-1) lands in group 0
        tag = "R6 reverse stride";
        send_frame(6, 3, 95);           // stride 2K-1

        // R9: stray beats without a start flag while idle
        sys_seen = 0; par_seen = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); in_valid = 1; in_first = 0; in_last = (i == 2); in_data = 1;
        end
        @(negedge clk); in_valid = 0; in_last = 0;
        repeat (20) @(negedge clk);
        check(sys_seen + par_seen == 0, "R9", sys_seen + par_seen, 0);
        check(in_ready == 1, "R9", int'(in_ready), 1);

        // R10: early closing flag abandons the frame
        for (int i = 0; i < 24; i++) tb_b[i] = bit'($urandom % 2);
        drive_bits(24, 10, 3, 1, 5);
        repeat (40) @(negedge clk);
        check(sys_seen + par_seen == 0, "R10", sys_seen + par_seen, 0);
        check(in_ready == 1, "R10", int'(in_ready), 1);

        ready_mode = 1;
        tag = "R4/R12 backpressure";
        send_frame(3, 1, 5);            // K=24, J=4
        tag = "R2/R4/R6 long frame";
        send_frame(100, 2, 7);          // K=800, J=8
        send_frame(5, 4, 79);           // back-to-back frame, accumulator restarts at 0

        run_done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule